// File: doc/BRIEF.md
# Packet Length Extractor with Cell Pad Calculator

This block sits beside a byte-wide packet stream and watches the first bytes of every IP packet. It counts the accepted bytes from the start-of-packet marker, takes the 16-bit total length from its fixed header position, and works out how many filler bytes are needed. That filler count is the number that makes the packet, together with the 8-byte trailer added later, fill a whole number of 48-byte cells. The stream itself is not touched: downstream stages read the length and the pad count from registered outputs.

The remainder modulo 48 comes from a short restoring subtract-and-compare loop, with no divider. A ready flag tells downstream logic when the length and pad outputs belong to the current packet. The ready flag drops as soon as the next packet starts. A packet that restarts before its computation ends abandons that computation.

Top module: `pktlen_pad`

## Requirements
- R1: While reset is low and after it is released, `out_ready`, `out_len` and `out_pad` are 0 until a packet header is seen.
- R2: A byte is accepted on a clock edge where `in_valid` is 1. The accepted byte with `in_sop` = 1 is header byte 0. `out_len` takes the big-endian value formed from header byte 2 (high byte) and header byte 3 (low byte).
- R3: When ready, `out_pad` equals (48 − ((`out_len` + 8) mod 48)) mod 48. This value lies in 0..47, and (`out_len` + `out_pad` + 8) is a multiple of 48.
- R4: `out_ready` goes high exactly at the 14th rising edge after the edge that accepts header byte 3, and is low at the edges before it.
- R5: The edge that accepts a byte with `in_sop` = 1 clears `out_ready`. A packet that starts while a computation is running abandons that computation.
- R6: Cycles with `in_valid` = 0 are ignored whatever `in_sop` and `in_data` carry: they do not advance the header byte position.
- R7: After reset, valid bytes that arrive before the first start-of-packet leave `out_len` unchanged. Bytes at header positions 4 and beyond never change `out_len`.
- R8: While `out_ready` is high, `out_len` and `out_pad` stay stable until the next start-of-packet byte is accepted.
- R9: A packet that ends before its header byte 3 leaves `out_ready` low and `out_len` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A byte is present on `in_data` |
| in_sop | input | 1 | The present byte is the first byte of a packet |
| in_data | input | 8 | Stream byte |
| out_len | output | 16 | Captured total length field |
| out_pad | output | 6 | Pad bytes needed for cell alignment |
| out_ready | output | 1 | Length and pad are valid for the current packet |

## Verification
Several properties are checked on every cycle. The cell-alignment sum holds whenever ready is high, and the remainder produced by the modulo loop is always below 48. The outputs stay stable while ready is high, a start-of-packet always clears ready on the next edge, and idle cycles never move the header position. Only the bench scenarios can show the rest. These are the exact 14-edge latency, the length value actually taken from header bytes 2 and 3, the abandonment of a computation when a packet restarts early, and short packets and pre-packet bytes that leave the outputs alone.

// File: rtl/lenpad_pkg.sv
// Shared constants and helpers for the length/pad block.
// Assumes: byte-wide stream, length field two bytes wide.
package lenpad_pkg;
    localparam int DEF_BYTE_W   = 8;
    localparam int DEF_CELL     = 48;
    localparam int DEF_TRAILER  = 8;
    localparam int DEF_HI_IDX   = 2;
    localparam int DEF_LO_IDX   = 3;
    localparam int DEF_IDX_W    = 3;

    // Largest shift s where div << s still fits in an in_w-bit word.
    function automatic int top_shift(input int in_w, input int div);
        return in_w - $clog2(div + 1);
    endfunction
endpackage

// File: rtl/lp_hdr_capture.sv
// Header position tracker and length field capture.
// Counts accepted bytes from start-of-packet (index 0). Stores the high
// length byte at HI_IDX. At LO_IDX it loads the full length and raises a
// strobe for one cycle. Assumes HI_IDX < LO_IDX < 2**IDX_W - 1. The count
// saturates, and it starts saturated so bytes before the first sop are ignored.
module lp_hdr_capture #(
    parameter int BYTE_W = 8,
    parameter int IDX_W  = 3,
    parameter int HI_IDX = 2,
    parameter int LO_IDX = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_sop,
    input  logic [BYTE_W-1:0]   in_data,
    output logic [2*BYTE_W-1:0] len_q,
    output logic                cap_stb,
    output logic [2*BYTE_W-1:0] cap_val
);
    localparam logic [IDX_W-1:0] IDX_MAX = '1;
    localparam logic [IDX_W-1:0] HI_POS  = IDX_W'(HI_IDX);
    localparam logic [IDX_W-1:0] LO_POS  = IDX_W'(LO_IDX);

    logic [IDX_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] hi_q;

    // Position of the byte currently on the bus.
    assign idx     = in_sop ? '0 : cnt_q;
    assign cap_stb = in_valid && (idx == LO_POS);
    assign cap_val = {hi_q, in_data};

    // Saturating count of accepted header bytes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= IDX_MAX;
        else if (in_valid)
            cnt_q <= (idx == IDX_MAX) ? IDX_MAX : idx + 1'b1;
    end

    // High length byte holding register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_q <= '0;
        else if (in_valid && idx == HI_POS)
            hi_q <= in_data;
    end

    // Full length register, loaded on the low byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            len_q <= '0;
        else if (cap_stb)
            len_q <= cap_val;
    end

    p_cnt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(cnt_q));

    p_len_only_on_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && idx == LO_POS) |=> $stable(len_q));
endmodule

// File: rtl/lp_mod_unit.sv
// Sequential remainder unit: operand mod DIV, by restoring subtraction.
// Starting from the largest shifted divisor that fits IN_W bits, each cycle
// subtracts DIV << step when possible. It takes SHIFT+1 cycles after start,
// then pulses done for one cycle with rem valid. abort drops a running job.
// Assumes start and abort are never high together.
module lp_mod_unit #(
    parameter int IN_W  = 17,
    parameter int DIV   = 48,
    parameter int RES_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic [IN_W-1:0]  operand,
    output logic [RES_W-1:0] rem,
    output logic             done
);
    localparam int SHIFT  = lenpad_pkg::top_shift(IN_W, DIV);
    localparam int STEP_W = $clog2(SHIFT + 1);
    localparam logic [STEP_W-1:0] STEP_TOP = STEP_W'(SHIFT);

    logic [IN_W-1:0]   rem_q;
    logic [STEP_W-1:0] step_q;
    logic              busy_q;
    logic [IN_W-1:0]   dsh;
    logic              fits;

    // Shifted divisor for the current step and the trial compare.
    assign dsh  = IN_W'(DIV) << step_q;
    assign fits = rem_q >= dsh;

    // Load, iterate, finish or abandon the remainder job.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            step_q <= '0;
            busy_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                busy_q <= 1'b0;
            end else if (start) begin
                rem_q  <= operand;
                step_q <= STEP_TOP;
                busy_q <= 1'b1;
            end else if (busy_q) begin
                if (fits)
                    rem_q <= rem_q - dsh;
                if (step_q == '0) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    step_q <= step_q - 1'b1;
                end
            end
        end
    end

    assign rem = rem_q[RES_W-1:0];

    p_rem_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rem_q < IN_W'(DIV)));
endmodule

// File: rtl/lp_ready_ctrl.sv
// Pad register and ready flag.
// On done it turns the remainder into a pad count (DIV - rem, or 0 when rem
// is 0). Ready rises on the cycle after the pad register loads and is cleared
// by clr (start of a packet). Assumes rem < DIV whenever done is high.
module lp_ready_ctrl #(
    parameter int DIV   = 48,
    parameter int RES_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done,
    input  logic             clr,
    input  logic [RES_W-1:0] rem,
    output logic [RES_W-1:0] pad_q,
    output logic             ready_q
);
    logic fresh_q;

    // Pad register, loaded when the remainder is complete.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pad_q <= '0;
        else if (done)
            pad_q <= (rem == '0) ? '0 : RES_W'(DIV) - rem;
    end

    // One-cycle marker that the pad register was just loaded.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fresh_q <= 1'b0;
        else
            fresh_q <= done && !clr;
    end

    // Ready flag: set after the pad loads, cleared by a new packet.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ready_q <= 1'b0;
        else if (clr)
            ready_q <= 1'b0;
        else if (fresh_q)
            ready_q <= 1'b1;
    end

    p_ready_after_pad_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_q) |-> $past(fresh_q));
endmodule

// File: rtl/pktlen_pad.sv
// Top: packet length extractor and cell pad calculator.
// Watches a byte stream (valid + sop) and captures the big-endian length
// from header bytes HI_IDX/LO_IDX. It computes the pad so that
// length + pad + TRAILER is a multiple of CELL, then flags ready. The stream
// passes by untouched. Assumes one byte per accepted beat.
module pktlen_pad #(
    parameter int BYTE_W  = lenpad_pkg::DEF_BYTE_W,
    parameter int CELL    = lenpad_pkg::DEF_CELL,
    parameter int TRAILER = lenpad_pkg::DEF_TRAILER,
    parameter int HI_IDX  = lenpad_pkg::DEF_HI_IDX,
    parameter int LO_IDX  = lenpad_pkg::DEF_LO_IDX,
    parameter int IDX_W   = lenpad_pkg::DEF_IDX_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_sop,
    input  logic [BYTE_W-1:0]        in_data,
    output logic [2*BYTE_W-1:0]      out_len,
    output logic [$clog2(CELL)-1:0]  out_pad,
    output logic                     out_ready
);
    localparam int LEN_W = 2 * BYTE_W;
    localparam int SUM_W = LEN_W + 1;
    localparam int PAD_W = $clog2(CELL);

    logic              cap_stb;
    logic [LEN_W-1:0]  cap_val;
    logic [SUM_W-1:0]  operand;
    logic              sop_hit;
    logic [PAD_W-1:0]  rem;
    logic              mod_done;

    // A start-of-packet byte accepted this cycle.
    assign sop_hit = in_valid && in_sop;
    // Length plus trailer is the quantity to align.
    assign operand = SUM_W'(cap_val) + SUM_W'(TRAILER);

    lp_hdr_capture #(
        .BYTE_W (BYTE_W),
        .IDX_W  (IDX_W),
        .HI_IDX (HI_IDX),
        .LO_IDX (LO_IDX)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sop   (in_sop),
        .in_data  (in_data),
        .len_q    (out_len),
        .cap_stb  (cap_stb),
        .cap_val  (cap_val)
    );

    lp_mod_unit #(
        .IN_W  (SUM_W),
        .DIV   (CELL),
        .RES_W (PAD_W)
    ) u_mod (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (cap_stb),
        .abort   (sop_hit),
        .operand (operand),
        .rem     (rem),
        .done    (mod_done)
    );

    lp_ready_ctrl #(
        .DIV   (CELL),
        .RES_W (PAD_W)
    ) u_rdy (
        .clk     (clk),
        .rst_n   (rst_n),
        .done    (mod_done),
        .clr     (sop_hit),
        .rem     (rem),
        .pad_q   (out_pad),
        .ready_q (out_ready)
    );

    p_sum_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_ready |-> (((SUM_W + 1)'(out_len) + (SUM_W + 1)'(out_pad)
                        + (SUM_W + 1)'(TRAILER)) % CELL == 0));

    p_ready_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sop_hit |=> !out_ready);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ready && !sop_hit) |=> (out_ready && $stable(out_len) && $stable(out_pad)));
endmodule

// File: tb/pktlen_pad_tb.sv
`timescale 1ns/1ps
module pktlen_pad_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_sop;
    logic [7:0]  in_data;
    logic [15:0] out_len;
    logic [5:0]  out_pad;
    logic        out_ready;

    int total = 0;
    int bad   = 0;
    int pos   = 0;
    bit armed = 0;
    bit sop_chk = 0;
    bit do_check = 0;
    bit ended = 0;
    int exp_len = 0;
    string len_tag = "R2";
    logic [15:0] last_len = '0;

    always #2 clk = ~clk;

    pktlen_pad u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sop    (in_sop),
        .in_data   (in_data),
        .out_len   (out_len),
        .out_pad   (out_pad),
        .out_ready (out_ready)
    );

    function automatic int exp_pad(input int len);
        return (48 - ((len + 8) % 48)) % 48;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // One cycle: check the state visible at the falling edge, then drive.
    task automatic do_cycle(input bit v, input bit s, input logic [7:0] d, input bit cap);
        @(negedge clk);
        if (sop_chk) begin
            chk(out_ready == 1'b0, "R5 ready cleared by sop", int'(out_ready), 0);
            sop_chk = 0;
        end
        if (armed) begin
            pos++;
            if (do_check) begin
                if (pos == 13)
                    chk(out_ready == 1'b0, "R4 ready low before latency", int'(out_ready), 0);
                if (pos == 14) begin
                    chk(out_ready == 1'b1, "R4 ready at latency", int'(out_ready), 1);
                    chk(int'(out_len) == exp_len, len_tag, int'(out_len), exp_len);
                    chk(int'(out_pad) == exp_pad(exp_len), "R3 pad value", int'(out_pad), exp_pad(exp_len));
                end
                if (pos == 17) begin
                    chk(out_ready == 1'b1, "R8 ready held", int'(out_ready), 1);
                    chk(int'(out_len) == exp_len && int'(out_pad) == exp_pad(exp_len),
                        "R8 R7 outputs held past header", int'(out_len), exp_len);
                end
            end
        end
        in_valid = v;
        in_sop   = s;
        in_data  = d;
        if (v && s) begin
            armed   = 0;
            sop_chk = 1;
        end
        if (cap) begin
            armed = 1;
            pos   = -1;
        end
    endtask

    task automatic send_pkt(input int len, input int nb, input int gap, input bit checked);
        do_check = checked;
        exp_len  = len;
        len_tag  = (gap > 0) ? "R2 R6 length with idle gaps" : "R2 length";
        for (int i = 0; i < nb; i++) begin
            logic [7:0] b;
            while (i > 0 && int'($urandom_range(99)) < gap)
                do_cycle(1'b0, 1'($urandom_range(1)), 8'($urandom_range(255)), 1'b0);
            b = (i == 2) ? 8'(len >> 8) : (i == 3) ? 8'(len) : 8'($urandom_range(255));
            do_cycle(1'b1, i == 0, b, i == 3);
        end
        if (nb >= 4) last_len = 16'(len);
        if (checked)
            while (pos < 17)
                do_cycle(1'b0, 1'b0, 8'($urandom_range(255)), 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_up();
    end

    initial begin
        void'($urandom(32'h0c0ffee5));
        rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_data = '0;
        repeat (4) @(negedge clk);
        chk(out_ready == 0 && out_len == 0 && out_pad == 0, "R1 reset state", int'(out_len), 0);
        rst_n = 1'b1;
        do_cycle(1'b0, 1'b0, 8'h00, 1'b0);
        do_cycle(1'b0, 1'b0, 8'h00, 1'b0);
        chk(out_ready == 0 && out_len == 0 && out_pad == 0, "R1 after release", int'(out_ready), 0);

        // R7: bytes before any start-of-packet are ignored.
        for (int i = 0; i < 8; i++) do_cycle(1'b1, 1'b0, 8'hA5 + 8'(i), 1'b0);
        repeat (20) do_cycle(1'b0, 1'b0, 8'h00, 1'b0);
        chk(out_len == 0 && out_ready == 0, "R7 pre-sop bytes ignored", int'(out_len), 0);

        // Directed corners of the pad formula.
        send_pkt(20,    24, 0, 1);
        send_pkt(40,    24, 0, 1);
        send_pkt(88,    30, 0, 1);
        send_pkt(39,    24, 0, 1);
        send_pkt(41,    24, 0, 1);
        send_pkt(65535, 28, 0, 1);
        send_pkt(65528, 28, 0, 1);
        send_pkt(1000,  26, 50, 1);

        // R5: restart during a computation, then a full packet.
        send_pkt(100, 10, 0, 0);
        send_pkt(333, 24, 0, 1);

        // R9: packet that ends before its low length byte.
        send_pkt(777, 3, 0, 0);
        repeat (20) do_cycle(1'b0, 1'b0, 8'h00, 1'b0);
        chk(out_ready == 1'b0, "R9 short packet no ready", int'(out_ready), 0);
        chk(out_len == last_len, "R9 short packet keeps length", int'(out_len), int'(last_len));

        // Random packets.
        for (int k = 0; k < 25; k++)
            send_pkt(int'($urandom_range(65535, 20)), int'($urandom_range(40, 20)),
                     int'($urandom_range(30)), 1);

        repeat (4) do_cycle(1'b0, 1'b0, 8'h00, 1'b0);
        finish_up();
    end
endmodule